// File: doc/BRIEF.md
# Shift and Rotate Unit

This is a purely combinational shift and rotate unit for a 32-bit integer datapath. Each operation is chosen by the instruction's six-bit function code. The unit handles four operations: logical left shift, logical right shift, arithmetic right shift and rotate right. The shift amount comes either from the five-bit immediate field of the instruction or from the low five bits of the rs operand. The data being shifted is always the rt operand.

Rotate right has no function code of its own. It shares its codes with logical right shift, and one encoding bit inside the instruction picks between the two. The immediate form and the register form each read a different bit. The decode of that bit is therefore part of the unit. The unit also raises a valid flag only when the function code is one of the six shift codes.

Top module: `shr_unit`

## Requirements
- R1: Function code 0x00 returns rt shifted left by the immediate amount, with zeros filling the low bits.
- R2: Function code 0x02 returns rt shifted right logically by the immediate amount when `rot_sel_imm` (instruction bit 21) is 0. It returns rt rotated right by that amount when `rot_sel_imm` is 1.
- R3: Function code 0x03 returns rt shifted right by the immediate amount, with rt bit 31 copied into every vacated high position.
- R4: Function codes 0x04, 0x06 and 0x07 take their amount from rs bits 4..0. Code 0x04 shifts left logically and code 0x07 shifts right arithmetically. The upper rs bits and the immediate field have no effect on the result.
- R5: Function code 0x06 returns a logical right shift when `rot_sel_var` (instruction bit 6) is 0, and a rotate right when it is 1.
- R6: A rotate right by n gives (rt << (32-n)) | (rt >> n) for n from 1 to 31. Any operation with an amount of zero returns rt unchanged.
- R7: Any function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 drives `valid` low and `result` to zero. The six shift codes drive `valid` high.
- R8: The immediate forms ignore `rot_sel_var` and rs. The register forms ignore `rot_sel_imm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func | input | 6 | Instruction function code |
| shamt_imm | input | 5 | Immediate shift amount field |
| rot_sel_imm | input | 1 | Rotate select for the immediate right form (instruction bit 21) |
| rot_sel_var | input | 1 | Rotate select for the register right form (instruction bit 6) |
| rs_val | input | 32 | rs operand; bits 4..0 give the register amount |
| rt_val | input | 32 | rt operand, the data being shifted |
| result | output | 32 | Shift or rotate result, zero when not valid |
| valid | output | 1 | High when func is a shift code |

## Verification
The bench builds the unit with its default data width of 32, which gives a five-bit amount and five shifter stages. At that width, all 64 function codes crossed with all 32 amounts can be covered exhaustively. Every pairing of operation and stage setting is reached, including amount zero and amount 31 for every operation. Random operands and random select bits are paired with each combination. The bench also randomises the rs upper bits and the unused immediate field, so the ignored inputs are exercised alongside the used ones.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNC_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNC_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FUNC_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FUNC_W-1:0] FN_SRAV = 6'h07;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SLL,
    OP_SRL,
    OP_SRA,
    OP_ROR
  } shr_op_e;
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic              rot_sel_imm,
  input  logic              rot_sel_var,
  output shr_op_e           op,
  output logic              from_reg,
  output logic              valid
);
  always_comb begin
    op       = OP_NONE;
    from_reg = 1'b0;
    valid    = 1'b1;
    unique case (func)
      FN_SLL:  op = OP_SLL;
      FN_SRL:  op = rot_sel_imm ? OP_ROR : OP_SRL;
      FN_SRA:  op = OP_SRA;
      FN_SLLV: begin op = OP_SLL; from_reg = 1'b1; end
      FN_SRLV: begin op = rot_sel_var ? OP_ROR : OP_SRL; from_reg = 1'b1; end
      FN_SRAV: begin op = OP_SRA; from_reg = 1'b1; end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/shr_amount.sv
module shr_amount #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0]  shamt_imm,
  input  logic [DATA_W-1:0] rs_val,
  input  logic              from_reg,
  output logic [AMT_W-1:0]  amt
);
  logic unused_rs_hi;
  assign unused_rs_hi = ^rs_val[DATA_W-1:AMT_W];

  always_comb begin
    amt = from_reg ? rs_val[AMT_W-1:0] : shamt_imm;
  end
endmodule

// File: rtl/shr_core.sv
module shr_core
  import shr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  shr_op_e           op,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [0:AMT_W];

  assign stage[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] moved;
    assign cur = stage[k];

    always_comb begin
      unique case (op)
        OP_SLL:  moved = {cur[DATA_W-1-S:0], {S{1'b0}}};
        OP_SRL:  moved = {{S{1'b0}}, cur[DATA_W-1:S]};
        OP_SRA:  moved = {{S{cur[DATA_W-1]}}, cur[DATA_W-1:S]};
        OP_ROR:  moved = {cur[S-1:0], cur[DATA_W-1:S]};
        default: moved = cur;
      endcase
    end

    assign stage[k+1] = amt[k] ? moved : cur;
  end

  always_comb begin
    dout = (op == OP_NONE) ? '0 : stage[AMT_W];
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [AMT_W-1:0]  shamt_imm,
  input  logic              rot_sel_imm,
  input  logic              rot_sel_var,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] result,
  output logic              valid
);
  shr_op_e          op;
  logic             from_reg;
  logic [AMT_W-1:0] amt;

  shr_decode u_dec (
    .func        (func),
    .rot_sel_imm (rot_sel_imm),
    .rot_sel_var (rot_sel_var),
    .op          (op),
    .from_reg    (from_reg),
    .valid       (valid)
  );

  shr_amount #(.DATA_W(DATA_W)) u_amt (
    .shamt_imm (shamt_imm),
    .rs_val    (rs_val),
    .from_reg  (from_reg),
    .amt       (amt)
  );

  shr_core #(.DATA_W(DATA_W)) u_core (
    .op   (op),
    .amt  (amt),
    .din  (rt_val),
    .dout (result)
  );
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk
  import shr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input logic [FUNC_W-1:0] func,
  input logic [AMT_W-1:0]  shamt_imm,
  input logic              rot_sel_imm,
  input logic              rot_sel_var,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] rt_val,
  input logic [DATA_W-1:0] result,
  input logic              valid
);
  logic [DATA_W-1:0] ones;
  logic              is_var;
  logic [AMT_W-1:0]  eff_amt;
  logic              is_rot;

  always_comb begin
    ones    = '1;
    is_var  = (func == FN_SLLV) || (func == FN_SRLV) || (func == FN_SRAV);
    eff_amt = is_var ? rs_val[AMT_W-1:0] : shamt_imm;
    is_rot  = ((func == FN_SRL) && rot_sel_imm) || ((func == FN_SRLV) && rot_sel_var);
  end

  always_comb begin
    // R7: non-shift codes give a zero result
    a_r7_idle_zero: assert (valid || result == '0);
    // R6: zero amount passes rt through
    a_r6_zero_pass: assert (!(valid && eff_amt == '0) || result == rt_val);
    // R1: left shift leaves the low bits clear
    a_r1_low_clear: assert (!(func == FN_SLL) || (result & ~(ones << shamt_imm)) == '0);
    // R4: variable left shift leaves the low bits clear
    a_r4_low_clear: assert (!(func == FN_SLLV) || (result & ~(ones << rs_val[AMT_W-1:0])) == '0);
    // R3: arithmetic right shift keeps the sign bit
    a_r3_sign_kept: assert (!(func == FN_SRA || func == FN_SRAV) || result[DATA_W-1] == rt_val[DATA_W-1]);
    // R2: logical right shift leaves the high bits clear
    a_r2_high_clear: assert (!(func == FN_SRL && !rot_sel_imm) || (result & ~(ones >> shamt_imm)) == '0);
    // R6: a rotate keeps the count of set bits
    a_r6_rot_popcount: assert (!is_rot || $countones(result) == $countones(rt_val));
  end
endmodule

bind shr_unit shr_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shr_unit_test.sv
module shr_unit_test;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [5:0]   func;
  logic [4:0]   shamt_imm;
  logic         rot_sel_imm;
  logic         rot_sel_var;
  logic [W-1:0] rs_val;
  logic [W-1:0] rt_val;
  logic [W-1:0] result;
  logic         valid;

  int n_run  = 0;
  int n_fail = 0;

  shr_unit uut (
    .func        (func),
    .shamt_imm   (shamt_imm),
    .rot_sel_imm (rot_sel_imm),
    .rot_sel_var (rot_sel_var),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .result      (result),
    .valid       (valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference: returns {valid, result}
  function automatic logic [W:0] model(input logic [5:0] f, input logic [4:0] imm,
                                       input logic si, input logic sv,
                                       input logic [W-1:0] rs, input logic [W-1:0] rt);
    int n;
    logic [W-1:0] r;
    n = (f == 6'h04 || f == 6'h06 || f == 6'h07) ? int'(rs[4:0]) : int'(imm);
    case (f)
      6'h00, 6'h04: r = rt << n;
      6'h03, 6'h07: r = W'($signed(rt) >>> n);
      6'h02: r = si ? ((n == 0) ? rt : ((rt << (W - n)) | (rt >> n))) : (rt >> n);
      6'h06: r = sv ? ((n == 0) ? rt : ((rt << (W - n)) | (rt >> n))) : (rt >> n);
      default: return {1'b0, {W{1'b0}}};
    endcase
    return {1'b1, r};
  endfunction

  function automatic string tag_of(input logic [5:0] f, input logic si, input logic sv);
    case (f)
      6'h00: return "R1";
      6'h02: return si ? "R6" : "R2";
      6'h03: return "R3";
      6'h04, 6'h07: return "R4";
      6'h06: return sv ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [5:0] f, input logic [4:0] imm, input logic si,
                       input logic sv, input logic [W-1:0] rs, input logic [W-1:0] rt,
                       input string tag);
    logic [W:0] exp;
    @(negedge clk);
    func = f; shamt_imm = imm; rot_sel_imm = si; rot_sel_var = sv;
    rs_val = rs; rt_val = rt;
    @(posedge clk);
    #1;
    exp = model(f, imm, si, sv, rs, rt);
    n_run++;
    if ({valid, result} !== exp) begin
      n_fail++;
      $display("FAIL %s func=%h amt=%0d got valid=%b res=%h expected valid=%b res=%h",
               tag, f, imm, valid, result, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic expect_val(input logic [W-1:0] exp, input string tag);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, result, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    func = 6'h3f; shamt_imm = '0; rot_sel_imm = 0; rot_sel_var = 0;
    rs_val = '0; rt_val = 32'h1234_5678;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R7: idle code at start
    n_run++;
    if (valid !== 1'b0 || result !== '0) begin
      n_fail++;
      $display("FAIL R7 start got valid=%b res=%h expected 0 0", valid, result);
    end

    // directed corner cases
    apply(6'h03, 5'd31, 0, 0, '0, 32'h8000_0000, "R3");
    expect_val(32'hFFFF_FFFF, "R3");
    apply(6'h02, 5'd1, 1, 0, '0, 32'h0000_0001, "R2");
    expect_val(32'h8000_0000, "R2");
    apply(6'h00, 5'd31, 0, 0, '0, 32'hFFFF_FFFF, "R1");
    expect_val(32'h8000_0000, "R1");
    apply(6'h02, 5'd0, 1, 1, '0, 32'hDEAD_BEEF, "R6");
    expect_val(32'hDEAD_BEEF, "R6");
    // R8: register rotate select has no effect on the immediate form
    apply(6'h02, 5'd4, 0, 1, 32'hFFFF_FFFF, 32'hF000_000F, "R8");
    expect_val(32'h0F00_0000, "R8");
    // R8: immediate rotate select has no effect on the register form
    apply(6'h06, 5'd9, 1, 0, 32'hABCD_E004, 32'hF000_000F, "R8");
    expect_val(32'h0F00_0000, "R8");
    // R5: register rotate
    apply(6'h06, 5'd0, 0, 1, 32'hFFFF_FFE4, 32'hF000_000F, "R5");
    expect_val(32'hFF00_0000, "R5");
    // R4: upper rs bits ignored
    apply(6'h04, 5'd31, 0, 0, 32'h8000_0008, 32'h0000_00FF, "R4");
    expect_val(32'h0000_FF00, "R4");

    // exhaustive codes x amounts with random operands
    for (int f = 0; f < 64; f++) begin
      for (int a = 0; a < 32; a++) begin
        logic [W-1:0] rs;
        logic [4:0]   imm;
        logic         si, sv;
        rs  = $urandom;
        imm = 5'($urandom);
        si  = 1'($urandom);
        sv  = 1'($urandom);
        if (f == 4 || f == 6 || f == 7) rs[4:0] = 5'(a);
        else imm = 5'(a);
        apply(6'(f), imm, si, sv, rs, $urandom, tag_of(6'(f), si, sv));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule